// File: doc/BRIEF.md
# Rate one-third convolutional encoder

This block turns a serial stream of information bits into coded words for forward error correction. Each accepted bit produces one 3-bit word. The word comes from a two-bit memory of earlier bits and three fixed tap patterns. The code is non-recursive and non-systematic, with constraint length 3. Bits arrive on a valid/ready handshake that carries an end-of-frame flag. Words leave through a registered valid/ready output.

When a frame's last bit has been taken, the encoder appends a tail by itself. It emits two more words with zero as the input, so the memory is back at all zeros before the next frame. No new bit is taken until the tail has gone into the output register. A downstream stall freezes both the encoder memory and the word on the output.

Top module: `conv3_encoder`

## Requirements
- R1: A synchronous active-high reset clears both memory bits and the output register. After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Bit 0 of `out_code` is the XOR of the current input bit, the previous bit and the bit before that (taps 1,1,1).
- R3: Bit 1 of `out_code` is the XOR of the previous bit and the bit before it. The current input is not used (taps 0,1,1).
- R4: Bit 2 of `out_code` is the XOR of the current input bit and the oldest stored bit (taps 1,0,1).
- R5: A bit accepted at a clock edge (`in_valid` and `in_ready` both high) appears as one word on the output from the next cycle. `out_valid` stays high until a cycle in which `out_ready` is high.
- R6: After a bit flagged with `in_last` is accepted, exactly two tail words follow it, in order. Each is encoded with a zero input bit.
- R7: `in_ready` is high only when no tail word is waiting to be loaded and the output register is empty or being read in that cycle. A bit offered while `in_ready` is low leaves the output stream unchanged.
- R8: While `out_valid` is high and `out_ready` is low, `out_code` and the encoder memory hold their values.
- R9: Every frame starts from an all-zero memory, so the first word of a frame depends only on its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Information bit is offered |
| in_ready | output | 1 | Encoder takes the offered bit at this edge |
| in_bit | input | 1 | Information bit |
| in_last | input | 1 | Offered bit is the last of its frame |
| out_valid | output | 1 | Coded word is held on `out_code` |
| out_ready | input | 1 | Downstream takes the word at this edge |
| out_code | output | 3 | Coded word; bit 0 from taps 1,1,1, bit 1 from 0,1,1, bit 2 from 1,0,1 |

## Verification
A one-bit frame gives the impulse response, which separates the three tap patterns and shows that the tail enters zeros. An all-ones frame and an alternating frame drive the memory into each of its states, and they would expose a swapped or missing tap. Random frames of random length, with gaps on the input and random stalls on the output, test the handshake. Because the next bit is held on the input during each tail, they also show that no bit is taken early and that back-to-back frames start from zero.

// File: rtl/conv3_pkg.sv
package conv3_pkg;
  // constraint length (current bit plus stored bits)
  localparam int unsigned CONV_K = 3;
  // coded bits per information bit
  localparam int unsigned CONV_N = 3;
  // tap masks, output j at [j*K +: K]; mask MSB taps the current bit
  localparam logic [CONV_N*CONV_K-1:0] CONV_GENS = {3'b101, 3'b011, 3'b111};

  function automatic int unsigned tail_words(input int unsigned k);
    return k - 1;
  endfunction
endpackage

// File: rtl/conv3_shift_reg.sv
module conv3_shift_reg #(
  parameter int unsigned K = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         din,
  output logic [K-1:0] window,
  output logic         state_zero
);
  // mem[K-2] is the newest stored bit, mem[0] the oldest
  logic [K-2:0] mem;

  assign window     = {din, mem};
  assign state_zero = (mem == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem <= '0;
    end else if (adv) begin
      mem <= window[K-1:1];
    end
  end
endmodule

// File: rtl/conv3_parity.sv
module conv3_parity #(
  parameter int unsigned              K    = 3,
  parameter int unsigned              N    = 3,
  parameter logic [N*K-1:0]           GENS = {3'b101, 3'b011, 3'b111}
) (
  input  logic [K-1:0] window,
  output logic [N-1:0] code
);
  for (genvar j = 0; j < N; j++) begin : g_tap
    assign code[j] = ^(window & GENS[j*K +: K]);
  end
endmodule

// File: rtl/conv3_tail_ctrl.sv
module conv3_tail_ctrl #(
  parameter int unsigned TAIL_LEN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic step,
  output logic busy
);
  localparam int unsigned CW = $clog2(TAIL_LEN + 1);

  logic [CW-1:0] left;

  assign busy = (left != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      left <= '0;
    end else if (start) begin
      left <= CW'(TAIL_LEN);
    end else if (step && busy) begin
      left <= left - 1'b1;
    end
  end
endmodule

// File: rtl/conv3_encoder.sv
module conv3_encoder
  import conv3_pkg::*;
#(
  parameter int unsigned      K    = CONV_K,
  parameter int unsigned      N    = CONV_N,
  parameter logic [N*K-1:0]   GENS = CONV_GENS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic         in_bit,
  input  logic         in_last,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [N-1:0] out_code
);
  localparam int unsigned TAIL_LEN = tail_words(K);

  logic         slot_free;
  logic         tail_busy;
  logic         take_bit;
  logic         take_tail;
  logic         adv;
  logic         enc_in;
  logic [K-1:0] window;
  logic         state_zero;
  logic [N-1:0] code_next;

  assign slot_free = !out_valid || out_ready;
  assign in_ready  = !tail_busy && slot_free;
  assign take_bit  = in_valid && in_ready;
  assign take_tail = tail_busy && slot_free;
  assign adv       = take_bit || take_tail;
  assign enc_in    = take_bit ? in_bit : 1'b0;

  conv3_shift_reg #(.K(K)) u_mem (
    .clk        (clk),
    .rst        (rst),
    .adv        (adv),
    .din        (enc_in),
    .window     (window),
    .state_zero (state_zero)
  );

  conv3_parity #(.K(K), .N(N), .GENS(GENS)) u_par (
    .window (window),
    .code   (code_next)
  );

  conv3_tail_ctrl #(.TAIL_LEN(TAIL_LEN)) u_tail (
    .clk   (clk),
    .rst   (rst),
    .start (take_bit && in_last),
    .step  (take_tail),
    .busy  (tail_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_code  <= '0;
    end else if (adv) begin
      out_valid <= 1'b1;
      out_code  <= code_next;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) $past(rst) |-> !out_valid);

  // R7
  tail_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
    tail_busy |-> !in_ready);

  // R6
  last_starts_tail_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_last) |=> tail_busy);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_code)));

  // R9
  tail_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tail_busy) |-> state_zero);
endmodule

// File: tb/conv3_encoder_test.sv
module conv3_encoder_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       in_bit = 1'b0;
  logic       in_last = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [2:0] out_code;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int q[$];          // expected words; bit 3 marks a tail word
  int s_new = 0;     // previous bit
  int s_old = 0;     // bit before that
  bit stall_prev = 0;
  logic [2:0] code_prev = '0;

  always #5 clk = ~clk;

  conv3_encoder uut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_bit    (in_bit),
    .in_last   (in_last),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_code  (out_code)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  function automatic int encode(input int u);
    int w;
    w = ((u ^ s_new ^ s_old) & 1)
      | (((s_new ^ s_old) & 1) << 1)
      | (((u ^ s_old) & 1) << 2);
    s_old = s_new;
    s_new = u;
    return w;
  endfunction

  task automatic step(input logic v, input logic b, input logic l, input logic r,
                      output logic acc);
    bit exp_vld;
    bit exp_rdy;
    int pend;
    @(negedge clk);
    in_valid  = v;
    in_bit    = b;
    in_last   = l;
    out_ready = r;
    #4;
    exp_vld = (q.size() > 0);
    chk(out_valid == exp_vld, "R5 out_valid", int'(out_valid), int'(exp_vld));
    pend = q.size() - (exp_vld ? 1 : 0);
    exp_rdy = (pend == 0) && (!exp_vld || r);
    chk(in_ready == exp_rdy, "R7 in_ready", int'(in_ready), int'(exp_rdy));
    if (exp_vld && out_valid) begin
      if (q[0][3]) begin
        chk(out_code == q[0][2:0], "R6 tail word", int'(out_code), q[0] & 7);
      end else begin
        chk(out_code[0] == q[0][0], "R2 bit0", int'(out_code[0]), q[0] & 1);
        chk(out_code[1] == q[0][1], "R3 bit1", int'(out_code[1]), (q[0] >> 1) & 1);
        chk(out_code[2] == q[0][2], "R4 bit2", int'(out_code[2]), (q[0] >> 2) & 1);
      end
    end
    if (stall_prev) begin
      chk(out_valid && (out_code == code_prev), "R8 stall hold",
          int'(out_code), int'(code_prev));
    end
    stall_prev = out_valid && !r;
    code_prev  = out_code;
    acc = v && in_ready;
    if (exp_vld && r) void'(q.pop_front());
    if (acc) begin
      q.push_back(encode(int'(b)));
      if (l) begin
        q.push_back(encode(0) | 8);
        q.push_back(encode(0) | 8);
      end
    end
  endtask

  function automatic logic pick_ready(input int mode);
    if (mode == 0) return 1'b1;
    return ($urandom % 3) != 0;
  endfunction

  task automatic send_frame(input logic [31:0] bits, input int len, input int mode);
    logic acc;
    for (int i = 0; i < len; i++) begin
      if (mode != 0 && ($urandom % 4) == 0) step(1'b0, 1'b0, 1'b0, pick_ready(mode), acc);
      do begin
        step(1'b1, bits[i], (i == len - 1), pick_ready(mode), acc);
      end while (!acc);
    end
  endtask

  task automatic drain();
    logic acc;
    for (int i = 0; i < 20 && q.size() > 0; i++) step(1'b0, 1'b0, 1'b0, 1'b1, acc);
    step(1'b0, 1'b0, 1'b0, 1'b1, acc);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state seen before the first edge out of reset
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

    // impulse: words 101, 011, 111 (R2 R3 R4 R6)
    send_frame(32'h1, 1, 0);
    drain();
    // all ones (R9: starts from zero after the tail)
    send_frame(32'hFFFF_FFFF, 6, 0);
    // alternating, back to back with the previous frame
    send_frame(32'hAAAA_AAAA, 8, 0);
    drain();
    // alternating with stalls
    send_frame(32'h5555_5555, 7, 1);
    for (int f = 0; f < 40; f++) begin
      send_frame($urandom, 1 + ($urandom % 12), (f % 3 == 0) ? 0 : 1);
    end
    drain();

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL R5 watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule